// File: doc/BRIEF.md
# Double-Buffered Serial Peripheral Controller

This block is a full-duplex SPI controller for a processor bus. Software writes the register map through a simple one-cycle read/write port. Transmit and receive each have a holding register in front of a shift register. While a word is on the wire, software can queue the next transmit word and still read the last received word. The data width, the bit order, the number of select lines and the serial clock divider are parameters. The controller's role, initiator (`IS_MASTER=1`) or responder (`IS_MASTER=0`), is also a parameter and cannot be changed at run time.

As initiator, the block makes the serial clock from the system clock. It idles low and uses mode 0: the transmit bit changes when the clock falls and is sampled when it rises. It drives active-low selects from a mask register and keeps them low for the whole word. As responder, it synchronises the incoming clock and select into the system clock domain. It loads its transmit holding register when it is selected, then shifts on the synchronised edges. In both roles, a finished word is copied to the receive holding register, and flags plus two maskable interrupt lines report progress.

Register map (word address on `reg_addr`):
- 0: received word, read only; bits above the data width read zero.
- 1: transmit word, write only.
- 2: status. Bit 0 is tx-ready, bit 1 is rx-ready, bit 2 is busy and bit 3 is overrun. A write to this address clears overrun.
- 3: control. Bit 0 enables the receive interrupt and bit 1 enables the transmit interrupt.
- 4: select mask.

Top module: `spi_core`

## Requirements
- R1: After reset the status reads 0x1 (tx-ready only), all select outputs are high, the serial clock output is low and both interrupt lines are low.
- R2: When the shifter is idle, a word written to address 1 is taken into the shifter on the next clock edge. Tx-ready reads 0 between the write and that edge, then 1 with busy set. A word written while busy is held, with tx-ready at 0, and is taken on the clock edge after the running word ends.
- R3: As initiator, each serial clock half period lasts `HALF_DIV` system clocks and a word takes `2*DATA_W` half periods. Rx-ready rises exactly `2*DATA_W*HALF_DIV+1` clock edges after the write edge of a word that starts an idle core.
- R4: With `LSB_FIRST=0`, the most significant bit goes first on the wire, and the same order is used for assembling received bits. Successive words go out in the order they were written.
- R5: Transfers are full duplex. The initiator drives `mosi_out` from its transmit shifter and samples `miso_in`. The responder drives `miso_out` and samples `mosi_in`. Each side's received word equals the word the other side sent.
- R6: A finished word is copied to the receive holding register. That register keeps its previous word while the next word shifts in. A read of address 0 with `reg_rd` high clears rx-ready.
- R7: If a word finishes while rx-ready is still set, the overrun bit (status bit 3) is set and the receive holding register takes the new word. A write to address 2 clears overrun.
- R8: As initiator, while a word is in flight `sel_n_out` equals the bitwise inverse of the mask register (address 4) for the whole word. When idle, all select outputs are high.
- R9: `irq_rx` equals rx-ready AND control bit 0, and `irq_tx` equals tx-ready AND control bit 1.
- R10: Only the low `DATA_W` bits of a transmit write go on the wire, and received words read back with all bits above `DATA_W` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe (side effects only) |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_rx | output | 1 | Receive-ready interrupt |
| irq_tx | output | 1 | Transmit-ready interrupt |
| sclk_out | output | 1 | Serial clock (initiator) |
| sel_n_out | output | NUM_SS | Active-low selects (initiator) |
| mosi_out | output | 1 | Serial data out (initiator) |
| miso_out | output | 1 | Serial data out (responder) |
| sclk_in | input | 1 | Serial clock in (responder) |
| sel_n_in | input | 1 | Select in, active low (responder) |
| mosi_in | input | 1 | Serial data in (responder) |
| miso_in | input | 1 | Serial data in (initiator) |

## Verification
The bench counts clock edges from each register write and checks results at fixed points.
- The tx-ready dip is sampled in the half cycle after the write edge.
- The reload, with busy set, is sampled one edge later.
- Rx-ready is sampled on both sides of edge `2*DATA_W*HALF_DIV+1` after the write: it must read 0 just before that edge and 1 just after it.

A responder instance finishes three clocks after the initiator because of its two-flop synchroniser and edge detector. The bench therefore waits four clocks before reading the responder. Queued-word and overrun results depend on word boundaries, so the bench polls status each clock until the boundary appears. All reads and comparisons are made on falling clock edges.

// File: rtl/spi_core_pkg.sv
package spi_core_pkg;

    typedef enum logic [2:0] {
        A_RXDATA = 3'd0,
        A_TXDATA = 3'd1,
        A_STATUS = 3'd2,
        A_CTRL   = 3'd3,
        A_SELECT = 3'd4
    } reg_addr_e;

    localparam int ST_TXRDY = 0;
    localparam int ST_RXRDY = 1;
    localparam int ST_BUSY  = 2;
    localparam int ST_OVR   = 3;

    localparam int CT_RXIE  = 0;
    localparam int CT_TXIE  = 1;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_SHIFT,
        ENG_HOLD
    } eng_state_e;

endpackage

// File: rtl/spi_clk_src.sv
module spi_clk_src #(
    parameter int IS_MASTER = 1,
    parameter int HALF_DIV  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sclk_in,
    input  logic sel_n_in,
    output logic sclk_out,
    output logic rise,
    output logic fall,
    output logic sel_act
);
    localparam int CW = $clog2(HALF_DIV + 1);

    generate
        if (IS_MASTER != 0) begin : g_master
            typedef struct packed {
                logic [CW-1:0] cnt;
                logic          sclk;
            } mclk_t;

            mclk_t mc_d, mc_q;
            logic  wrap;
            logic  unused_slave_pins;

            assign unused_slave_pins = sclk_in ^ sel_n_in;
            assign wrap = run && (mc_q.cnt == CW'(HALF_DIV - 1));

            always_comb begin
                mc_d = mc_q;
                if (!run) begin
                    mc_d.cnt  = '0;
                    mc_d.sclk = 1'b0;
                end else if (wrap) begin
                    mc_d.cnt  = '0;
                    mc_d.sclk = ~mc_q.sclk;
                end else begin
                    mc_d.cnt  = mc_q.cnt + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) mc_q <= '0;
                else        mc_q <= mc_d;
            end

            assign sclk_out = mc_q.sclk;
            assign rise     = wrap & ~mc_q.sclk;
            assign fall     = wrap &  mc_q.sclk;
            assign sel_act  = 1'b0;

            // R3: the generated clock rests low whenever the engine is not shifting
            p_sclk_low_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
                !run |-> !mc_q.sclk);
        end else begin : g_slave
            typedef struct packed {
                logic s1;
                logic s2;
                logic prev;
                logic c1;
                logic c2;
            } sync_t;

            sync_t sy_d, sy_q;
            logic  unused_run;

            assign unused_run = run;

            always_comb begin
                sy_d      = sy_q;
                sy_d.s1   = sclk_in;
                sy_d.s2   = sy_q.s1;
                sy_d.prev = sy_q.s2;
                sy_d.c1   = sel_n_in;
                sy_d.c2   = sy_q.c1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sy_q <= '{s1: 1'b0, s2: 1'b0, prev: 1'b0, c1: 1'b1, c2: 1'b1};
                else        sy_q <= sy_d;
            end

            assign sclk_out = 1'b0;
            assign rise     =  sy_q.s2 & ~sy_q.prev;
            assign fall     = ~sy_q.s2 &  sy_q.prev;
            assign sel_act  = ~sy_q.c2;
        end
    endgenerate

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_core_pkg::*;
#(
    parameter int W         = 8,
    parameter int LSB_FIRST = 0,
    parameter int IS_MASTER = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_valid,
    input  logic [W-1:0] tx_word,
    input  logic         rise,
    input  logic         fall,
    input  logic         sel_act,
    input  logic         ser_in,
    output logic         tx_take,
    output logic         busy,
    output logic         ser_out,
    output logic         rx_done,
    output logic [W-1:0] rx_word
);
    localparam int CNT_W = $clog2(W + 1);

    typedef struct packed {
        eng_state_e     state;
        logic [W-1:0]   tx_sh;
        logic [W-1:0]   rx_sh;
        logic [CNT_W-1:0] bitcnt;
    } eng_t;

    eng_t eg_d, eg_q;
    logic start;
    logic last_bit;

    assign start    = (IS_MASTER != 0) ? tx_valid : sel_act;
    assign last_bit = (eg_q.bitcnt == CNT_W'(W));

    always_comb begin
        eg_d    = eg_q;
        tx_take = 1'b0;
        rx_done = 1'b0;
        case (eg_q.state)
            ENG_IDLE: begin
                if (start) begin
                    eg_d.state  = ENG_SHIFT;
                    eg_d.bitcnt = '0;
                    eg_d.tx_sh  = tx_valid ? tx_word : '0;
                    tx_take     = tx_valid;
                end
            end
            ENG_SHIFT: begin
                if (rise) begin
                    eg_d.rx_sh  = (LSB_FIRST != 0) ? {ser_in, eg_q.rx_sh[W-1:1]}
                                                   : {eg_q.rx_sh[W-2:0], ser_in};
                    eg_d.bitcnt = eg_q.bitcnt + 1'b1;
                end
                if (fall) begin
                    if (last_bit) begin
                        rx_done    = 1'b1;
                        eg_d.state = ((IS_MASTER != 0) || !sel_act) ? ENG_IDLE : ENG_HOLD;
                    end else begin
                        eg_d.tx_sh = (LSB_FIRST != 0) ? (eg_q.tx_sh >> 1) : (eg_q.tx_sh << 1);
                    end
                end else if ((IS_MASTER == 0) && !sel_act) begin
                    eg_d.state = ENG_IDLE;
                end
            end
            ENG_HOLD: begin
                if (!sel_act) eg_d.state = ENG_IDLE;
            end
            default: eg_d.state = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eg_q <= '{state: ENG_IDLE, tx_sh: '0, rx_sh: '0, bitcnt: '0};
        else        eg_q <= eg_d;
    end

    assign busy    = (eg_q.state != ENG_IDLE);
    assign ser_out = (eg_q.state == ENG_SHIFT) &
                     ((LSB_FIRST != 0) ? eg_q.tx_sh[0] : eg_q.tx_sh[W-1]);
    assign rx_word = eg_q.rx_sh;

    // R3: a word never counts more sampled bits than the configured width
    p_bitcnt_le_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eg_q.bitcnt <= CNT_W'(W));

endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
    import spi_core_pkg::*;
#(
    parameter int W      = 8,
    parameter int NUM_SS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        addr,
    input  logic              wr,
    input  logic [31:0]       wdata,
    input  logic              rd,
    output logic [31:0]       rdata,
    input  logic              tx_take,
    input  logic              rx_done,
    input  logic [W-1:0]      rx_word,
    input  logic              busy,
    output logic              tx_valid,
    output logic [W-1:0]      tx_word,
    output logic [NUM_SS-1:0] sel_mask,
    output logic              irq_rx,
    output logic              irq_tx
);
    typedef struct packed {
        logic [W-1:0]      tx_hold;
        logic              tx_full;
        logic [W-1:0]      rx_hold;
        logic              rx_full;
        logic              overrun;
        logic [1:0]        ctrl;
        logic [NUM_SS-1:0] mask;
    } rf_t;

    rf_t  rf_d, rf_q;
    logic wr_tx, rd_rx, wr_st;
    logic unused_wdata;

    assign unused_wdata = ^wdata;
    assign wr_tx = wr && (addr == A_TXDATA);
    assign wr_st = wr && (addr == A_STATUS);
    assign rd_rx = rd && (addr == A_RXDATA);

    always_comb begin
        rf_d = rf_q;
        if (tx_take) rf_d.tx_full = 1'b0;
        if (wr_tx) begin
            rf_d.tx_hold = wdata[W-1:0];
            rf_d.tx_full = 1'b1;
        end
        if (wr && (addr == A_CTRL))   rf_d.ctrl = wdata[1:0];
        if (wr && (addr == A_SELECT)) rf_d.mask = wdata[NUM_SS-1:0];
        if (wr_st) rf_d.overrun = 1'b0;
        if (rd_rx) rf_d.rx_full = 1'b0;
        if (rx_done) begin
            rf_d.rx_hold = rx_word;
            rf_d.rx_full = 1'b1;
            if (rf_q.rx_full && !rd_rx) rf_d.overrun = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_RXDATA: rdata[W-1:0] = rf_q.rx_hold;
            A_STATUS: begin
                rdata[ST_TXRDY] = ~rf_q.tx_full;
                rdata[ST_RXRDY] = rf_q.rx_full;
                rdata[ST_BUSY]  = busy;
                rdata[ST_OVR]   = rf_q.overrun;
            end
            A_CTRL:   rdata[1:0] = rf_q.ctrl;
            A_SELECT: rdata[NUM_SS-1:0] = rf_q.mask;
            default:  rdata = '0;
        endcase
    end

    assign tx_valid = rf_q.tx_full;
    assign tx_word  = rf_q.tx_hold;
    assign sel_mask = rf_q.mask;
    assign irq_rx   = rf_q.rx_full  & rf_q.ctrl[CT_RXIE];
    assign irq_tx   = ~rf_q.tx_full & rf_q.ctrl[CT_TXIE];

    // R2: a word handed to the shifter empties the holding register
    p_take_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_take && !wr_tx) |=> !rf_q.tx_full);
    // R7: completion over an unread word flags overrun
    p_overrun_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rf_q.rx_full && !rd_rx) |=> rf_q.overrun);
    // R6: reading the received word drops rx-ready
    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && !rx_done) |=> !rf_q.rx_full);

endmodule

// File: rtl/spi_core.sv
module spi_core
    import spi_core_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int NUM_SS    = 4,
    parameter int IS_MASTER = 1,
    parameter int LSB_FIRST = 0,
    parameter int HALF_DIV  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_rd,
    output logic [31:0]       reg_rdata,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic              sclk_out,
    output logic [NUM_SS-1:0] sel_n_out,
    output logic              mosi_out,
    output logic              miso_out,
    input  logic              sclk_in,
    input  logic              sel_n_in,
    input  logic              mosi_in,
    input  logic              miso_in
);
    logic              tx_valid, tx_take, busy, rx_done;
    logic [DATA_W-1:0] tx_word, rx_word;
    logic [NUM_SS-1:0] sel_mask;
    logic              rise, fall, sel_act, ser_in, ser_out;

    spi_regfile #(.W(DATA_W), .NUM_SS(NUM_SS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata), .rd(reg_rd), .rdata(reg_rdata),
        .tx_take(tx_take), .rx_done(rx_done), .rx_word(rx_word), .busy(busy),
        .tx_valid(tx_valid), .tx_word(tx_word), .sel_mask(sel_mask),
        .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    spi_clk_src #(.IS_MASTER(IS_MASTER), .HALF_DIV(HALF_DIV)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(busy),
        .sclk_in(sclk_in), .sel_n_in(sel_n_in),
        .sclk_out(sclk_out), .rise(rise), .fall(fall), .sel_act(sel_act)
    );

    spi_shift_engine #(.W(DATA_W), .LSB_FIRST(LSB_FIRST), .IS_MASTER(IS_MASTER)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(tx_valid), .tx_word(tx_word),
        .rise(rise), .fall(fall), .sel_act(sel_act), .ser_in(ser_in),
        .tx_take(tx_take), .busy(busy), .ser_out(ser_out),
        .rx_done(rx_done), .rx_word(rx_word)
    );

    generate
        if (IS_MASTER != 0) begin : g_init_pins
            logic unused_resp_pins;
            assign unused_resp_pins = mosi_in;
            assign ser_in    = miso_in;
            assign mosi_out  = ser_out;
            assign miso_out  = 1'b0;
            assign sel_n_out = busy ? ~sel_mask : '1;
        end else begin : g_resp_pins
            logic unused_init_pins;
            assign unused_init_pins = miso_in ^ (^sel_mask);
            assign ser_in    = mosi_in;
            assign miso_out  = ser_out;
            assign mosi_out  = 1'b0;
            assign sel_n_out = '1;
        end
    endgenerate

endmodule

// File: tb/spi_core_tb_top.sv
module spi_core_tb_top;
    localparam int W    = 8;
    localparam int NSS  = 4;
    localparam int HD   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [2:0]  m_addr = '0, s_addr = '0;
    logic        m_wr = 0, s_wr = 0, m_rd = 0, s_rd = 0;
    logic [31:0] m_wdata = '0, s_wdata = '0, m_rdata, s_rdata;
    logic        m_irq_rx, m_irq_tx, s_irq_rx, s_irq_tx;
    logic        m_sclk, m_mosi, m_miso_o, s_sclk, s_mosi_o, s_miso;
    logic [NSS-1:0] m_sel_n, s_sel_n;

    spi_core #(.DATA_W(W), .NUM_SS(NSS), .IS_MASTER(1), .LSB_FIRST(0), .HALF_DIV(HD)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(m_addr), .reg_wr(m_wr), .reg_wdata(m_wdata),
        .reg_rd(m_rd), .reg_rdata(m_rdata), .irq_rx(m_irq_rx), .irq_tx(m_irq_tx),
        .sclk_out(m_sclk), .sel_n_out(m_sel_n), .mosi_out(m_mosi), .miso_out(m_miso_o),
        .sclk_in(1'b0), .sel_n_in(1'b1), .mosi_in(1'b0), .miso_in(s_miso)
    );

    spi_core #(.DATA_W(W), .NUM_SS(NSS), .IS_MASTER(0), .LSB_FIRST(0), .HALF_DIV(HD)) peer_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(s_addr), .reg_wr(s_wr), .reg_wdata(s_wdata),
        .reg_rd(s_rd), .reg_rdata(s_rdata), .irq_rx(s_irq_rx), .irq_tx(s_irq_tx),
        .sclk_out(s_sclk), .sel_n_out(s_sel_n), .mosi_out(s_mosi_o), .miso_out(s_miso),
        .sclk_in(m_sclk), .sel_n_in(&m_sel_n), .mosi_in(m_mosi), .miso_in(1'b0)
    );

    int total = 0, failed = 0;
    bit finished = 0;
    logic [31:0] cap = '0;
    int bits = 0, sel_bad = 0;
    logic [NSS-1:0] exp_mask = '0;
    logic sclk_prev = 1'b0;

    function automatic logic [31:0] exp_word(input logic [31:0] v);
        return v & ((32'd1 << W) - 32'd1);
    endfunction

    function automatic logic [31:0] exp_status(input bit txr, rxr, bsy, ovr);
        return {28'd0, ovr, bsy, rxr, txr};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    endtask

    // serial monitor: bits seen on rising serial clock, sampled on falling system clock
    always @(negedge clk) begin
        if (m_sclk && !sclk_prev) begin
            cap = {cap[30:0], m_mosi};
            bits++;
            if (m_sel_n !== ~exp_mask) sel_bad++;
        end
        sclk_prev = m_sclk;
    end

    task automatic bus_write(input bit peer, input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        if (peer) begin s_addr = a; s_wdata = v; s_wr = 1; end
        else      begin m_addr = a; m_wdata = v; m_wr = 1; end
        @(negedge clk);
        s_wr = 0; m_wr = 0;
    endtask

    task automatic peek(input bit peer, input logic [2:0] a, output logic [31:0] v);
        if (peer) s_addr = a; else m_addr = a;
        #1;
        v = peer ? s_rdata : m_rdata;
    endtask

    task automatic bus_read(input bit peer, input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        if (peer) begin s_addr = a; s_rd = 1; end
        else      begin m_addr = a; m_rd = 1; end
        #1;
        v = peer ? s_rdata : m_rdata;
        @(negedge clk);
        s_rd = 0; m_rd = 0;
    endtask

    task automatic wait_flag(input bit peer, input int bitpos, input string req);
        logic [31:0] st;
        bit seen = 0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            @(negedge clk);
            peek(peer, 3'd2, st);
            seen = st[bitpos];
        end
        if (!seen) chk(req, 32'd0, 32'd1);
    endtask

    task automatic xfer(input logic [31:0] mv, input logic [31:0] sv, input logic [NSS-1:0] mask);
        logic [31:0] r;
        exp_mask = mask;
        bus_write(0, 3'd4, 32'(mask));
        bus_write(1, 3'd1, sv);
        cap = '0; bits = 0; sel_bad = 0;
        bus_write(0, 3'd1, mv);
        wait_flag(0, 1, "R3 word completion");
        repeat (4) @(negedge clk);
        chk("R8 selects high when idle", 32'(m_sel_n), 32'(4'hF));
        bus_read(0, 3'd0, r);
        chk("R5/R10 initiator received responder word", r, exp_word(sv));
        bus_read(1, 3'd0, r);
        chk("R5/R10 responder received initiator word", r, exp_word(mv));
        chk("R4 MSB-first wire order", cap & 32'hFF, exp_word(mv));
        chk("R3 bits per word", 32'(bits), 32'(W));
        chk("R8 selects held for whole word", 32'(sel_bad), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; failed++;
        $display("FAIL watchdog actual=timeout expected=completion");
        report();
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd1234));
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        peek(0, 3'd2, r);
        chk("R1 reset status", r, exp_status(1, 0, 0, 0));
        chk("R1 reset selects", 32'(m_sel_n), 32'(4'hF));
        chk("R1 reset sclk", 32'(m_sclk), 32'd0);
        chk("R1 reset irqs", {30'd0, m_irq_rx, m_irq_tx}, 32'd0);

        // R2 / R3 exact timing of one word
        exp_mask = 4'h2;
        bus_write(0, 3'd4, 32'h2);
        bus_write(1, 3'd1, 32'hC3);
        cap = '0; bits = 0; sel_bad = 0;
        bus_write(0, 3'd1, 32'hA5);
        peek(0, 3'd2, r);
        chk("R2 tx-ready low before take", r, exp_status(0, 0, 0, 0));
        @(negedge clk);
        peek(0, 3'd2, r);
        chk("R2 taken on next edge", r, exp_status(1, 0, 1, 0));
        chk("R8 selects equal inverse mask", 32'(m_sel_n), 32'(4'hD));
        repeat (2*W*HD - 1) @(negedge clk);
        peek(0, 3'd2, r);
        chk("R3 rx-ready not yet set", 32'(r[1]), 32'd0);
        @(negedge clk);
        peek(0, 3'd2, r);
        chk("R3 rx-ready at exact edge", 32'(r[1]), 32'd1);
        chk("R8 selects released", 32'(m_sel_n), 32'(4'hF));
        repeat (4) @(negedge clk);
        bus_read(0, 3'd0, r);
        chk("R5 initiator rx", r, 32'hC3);
        bus_read(1, 3'd0, r);
        chk("R5 responder rx", r, 32'hA5);
        chk("R4 wire order", cap & 32'hFF, 32'hA5);
        chk("R8 select held", 32'(sel_bad), 32'd0);
        peek(0, 3'd2, r);
        chk("R6 read clears rx-ready", r, exp_status(1, 0, 0, 0));

        // R2 / R6 / R7 queued word and overrun
        bus_write(1, 3'd1, 32'h11);
        cap = '0; bits = 0; sel_bad = 0;
        bus_write(0, 3'd1, 32'h22);
        repeat (20) @(negedge clk);
        bus_write(0, 3'd1, 32'h44);
        peek(0, 3'd2, r);
        chk("R2 queued word held while busy", r, exp_status(0, 0, 1, 0));
        bus_write(1, 3'd1, 32'h33);
        wait_flag(0, 1, "R6 first word done");
        peek(0, 3'd0, r);
        chk("R6 first received word", r, 32'h11);
        @(negedge clk);
        peek(0, 3'd2, r);
        chk("R2 queued word taken after word end", r, exp_status(1, 1, 1, 0));
        repeat (40) @(negedge clk);
        peek(0, 3'd0, r);
        chk("R6 holding keeps prior word mid-shift", r, 32'h11);
        wait_flag(0, 3, "R7 overrun raised");
        peek(0, 3'd0, r);
        chk("R7 new word replaces unread", r, 32'h33);
        peek(0, 3'd2, r);
        chk("R7 status with overrun", r, exp_status(1, 1, 0, 1));
        bus_write(0, 3'd2, 32'h0);
        peek(0, 3'd2, r);
        chk("R7 status write clears overrun", r, exp_status(1, 1, 0, 0));
        bus_read(0, 3'd0, r);
        peek(0, 3'd2, r);
        chk("R6 read clears rx-ready", r, exp_status(1, 0, 0, 0));
        chk("R4 words in write order", cap & 32'hFFFF, 32'h2244);
        repeat (4) @(negedge clk);
        peek(1, 3'd2, r);
        chk("R7 responder overrun", r, exp_status(1, 1, 0, 1));
        bus_read(1, 3'd0, r);
        chk("R5 responder second word", r, 32'h44);
        bus_write(1, 3'd2, 32'h0);

        // R9 interrupts
        bus_write(0, 3'd3, 32'h3);
        chk("R9 irq_tx with tx-ready", 32'(m_irq_tx), 32'd1);
        chk("R9 irq_rx without rx-ready", 32'(m_irq_rx), 32'd0);
        bus_write(1, 3'd1, 32'h0F);
        bus_write(0, 3'd1, 32'hF0);
        wait_flag(0, 1, "R9 word done");
        chk("R9 irq_rx raised", 32'(m_irq_rx), 32'd1);
        bus_write(0, 3'd3, 32'h1);
        chk("R9 rx only enabled", {30'd0, m_irq_rx, m_irq_tx}, 32'h2);
        bus_write(0, 3'd3, 32'h2);
        chk("R9 tx only enabled", {30'd0, m_irq_rx, m_irq_tx}, 32'h1);
        bus_write(0, 3'd3, 32'h0);
        chk("R9 both masked", {30'd0, m_irq_rx, m_irq_tx}, 32'h0);
        repeat (4) @(negedge clk);
        bus_read(0, 3'd0, r);
        bus_read(1, 3'd0, r);

        // R10 width truncation
        xfer(32'hABCD_125A, 32'hFFFF_FF3C, 4'h8);

        // random traffic
        for (int i = 0; i < 16; i++) begin
            logic [NSS-1:0] mk;
            mk = NSS'($urandom_range(1, 15));
            xfer($urandom(), $urandom(), mk);
        end

        report();
    end

endmodule